// File: doc/BRIEF.md
# Multiple-Response Resolver

After an associative search, every stored word raises or lowers its own responder flag. This block captures that N-bit responder vector and summarises it in two ways. A three-way status says whether there is no responder, exactly one, or more than one. An exact count gives the number of responders. It also serialises the responders. It presents the index of the responder in the lowest word position. Each `next` command retires that responder, and the following one is then presented.

The flags sit in a square array of √N rows by √N columns. A per-row activity bit is formed first. The lowest active row is then chosen, and only that row's bits are scanned for the lowest active column. The index is the row number times √N plus the column. All outputs are derived from one registered flag set. Every result therefore reflects the most recent `load` or `next`, one clock edge after it.

Top module: `resp_resolver`

## Requirements
- R1: `status` encodes the remaining flags as 2'd0 when none are set, 2'd1 when exactly one is set and 2'd2 when two or more are set.
- R2: `count` equals the number of flags that remain set.
- R3: While any flag is set, `valid` is 1 and `index` is the position of the lowest-numbered set flag (bit 0 is position 0 and has highest priority).
- R4: A `load` pulse replaces the whole flag set with `resp_vec` at the clock edge. All outputs show the new set after that edge. When `load` and `next` are both high, `load` wins and nothing is cleared.
- R5: A `next` pulse (without `load`) clears the flag currently shown by `index`. `next` while `valid` is 0 has no effect.
- R6: When no flag remains, `valid` is 0 and `index` is 0.
- R7: `status` and `count` are recomputed from the remaining flags after every `next`, so draining k responders takes the count down by one per `next`.
- R8: While `rst_n` is low, the flag set is empty: `status` 0, `count` 0 and `valid` 0.
- R9: Selection is correct across the row/column split. Empty rows are skipped, and a responder in the last row and last column (position N-1) is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resp_vec | input | N | Responder flags from the search |
| load | input | 1 | Capture `resp_vec` as the new flag set |
| next | input | 1 | Retire the currently selected responder |
| status | output | 2 | 0 none, 1 exactly one, 2 several |
| count | output | $clog2(N+1) | Number of remaining responders |
| index | output | $clog2(N) | Position of the selected responder |
| valid | output | 1 | A responder is selected |

## Verification
Every output is a combinational function of the flag register, so each result is due one rising edge after the `load` or `next` that caused it. The bench drives inputs just after a falling edge. It lets one rising edge pass and samples 1 time unit later, before the next edge. Stimulus is then removed, so each check sees exactly one command's effect. A reference copy of the flags is updated at the same point. The expected status, count and index are derived from it by bench functions, both during random drains and during directed row-boundary, simultaneous-command and empty-set cases.

// File: rtl/rr_pkg.sv
package rr_pkg;

   typedef enum logic [1:0] {
      RS_NONE = 2'd0,
      RS_ONE  = 2'd1,
      RS_MANY = 2'd2
   } rr_status_e;

   // integer square root, used to size the row/column array
   function automatic int isqrt(input int n);
      int r;
      r = 0;
      while ((r + 1) * (r + 1) <= n) r++;
      return r;
   endfunction

endpackage

// File: rtl/rr_flagstore.sv
module rr_flagstore #(
   parameter int N  = 64,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [N-1:0]  vec,
   input  logic          clr_en,
   input  logic [IW-1:0] clr_idx,
   output logic [N-1:0]  flags
);

   always_ff @(posedge clk) begin
      if (!rst_n)      flags <= '0;
      else if (load)   flags <= vec;
      else if (clr_en) flags[clr_idx] <= 1'b0;
   end

   // load replaces the entire set, clear or not
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> flags == $past(vec));

   // a clear removes exactly the addressed flag
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !load) |=> !flags[$past(clr_idx)]);

endmodule

// File: rtl/rr_popcount.sv
module rr_popcount #(
   parameter int R  = 8,
   parameter int C  = 8,
   parameter int CW = $clog2(R*C+1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [R*C-1:0] flags,
   output logic [CW-1:0] count
);
   localparam int RCW = $clog2(C + 1);

   logic [RCW-1:0] row_sum [R];

   for (genvar r = 0; r < R; r++) begin : g_row
      always_comb begin
         row_sum[r] = '0;
         for (int c = 0; c < C; c++)
            row_sum[r] = row_sum[r] + RCW'(flags[r*C + c]);
      end
   end

   always_comb begin
      count = '0;
      for (int r = 0; r < R; r++)
         count = count + CW'(row_sum[r]);
   end

   assert_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) == $countones(flags));

endmodule

// File: rtl/rr_twolevel_pick.sv
module rr_twolevel_pick #(
   parameter int R  = 8,
   parameter int C  = 8,
   parameter int IW = $clog2(R*C)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [R*C-1:0] flags,
   output logic           valid,
   output logic [IW-1:0]  index
);
   localparam int N = R * C;

   logic [R-1:0] row_act;
   logic [C-1:0] row_bits;
   int           sel_row;
   int           sel_col;

   // level one: activity per row
   for (genvar r = 0; r < R; r++) begin : g_act
      assign row_act[r] = |flags[r*C +: C];
   end

   // lowest active row
   always_comb begin
      sel_row = 0;
      for (int r = R - 1; r >= 0; r--)
         if (row_act[r]) sel_row = r;
   end

   // level two: scan only the chosen row
   always_comb begin
      row_bits = flags[sel_row*C +: C];
      sel_col  = 0;
      for (int c = C - 1; c >= 0; c--)
         if (row_bits[c]) sel_col = c;
   end

   assign valid = |row_act;
   assign index = IW'(sel_row * C + sel_col);

   logic [N-1:0] below_mask;
   assign below_mask = (N'(1) << index) - N'(1);

   assert_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (flags[index] && ((flags & below_mask) == '0)));

endmodule

// File: rtl/resp_resolver.sv
module resp_resolver #(
   parameter int N = 64
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N-1:0]           resp_vec,
   input  logic                   load,
   input  logic                   next,
   output logic [1:0]             status,
   output logic [$clog2(N+1)-1:0] count,
   output logic [$clog2(N)-1:0]   index,
   output logic                   valid
);
   import rr_pkg::*;

   localparam int R  = isqrt(N);
   localparam int C  = N / R;
   localparam int IW = $clog2(N);
   localparam int CW = $clog2(N + 1);

   if (R * R != N) begin : g_bad_n
      $error("resp_resolver: N must be a perfect square");
   end
   if (N < 4) begin : g_small_n
      $error("resp_resolver: N must be at least 4");
   end

   logic [N-1:0] flags;
   logic         clr_en;
   rr_status_e   stat_e;

   assign clr_en = next & valid;

   rr_flagstore #(.N(N), .IW(IW)) u_store (
      .clk(clk), .rst_n(rst_n), .load(load), .vec(resp_vec),
      .clr_en(clr_en), .clr_idx(index), .flags(flags)
   );

   rr_popcount #(.R(R), .C(C), .CW(CW)) u_count (
      .clk(clk), .rst_n(rst_n), .flags(flags), .count(count)
   );

   rr_twolevel_pick #(.R(R), .C(C), .IW(IW)) u_pick (
      .clk(clk), .rst_n(rst_n), .flags(flags), .valid(valid), .index(index)
   );

   always_comb begin
      if (count == '0)               stat_e = RS_NONE;
      else if (count == CW'(1))      stat_e = RS_ONE;
      else                           stat_e = RS_MANY;
   end
   assign status = stat_e;

   // status agrees with the independently derived selection
   assert_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (status == RS_NONE) == !valid);

   assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (index == '0));

   assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (next && !load && valid) |=> (count == $past(count) - CW'(1)));

   assert_idle_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (next && !load && !valid) |=> $stable(count));

endmodule

// File: tb/sim_resp_resolver.sv
module sim_resp_resolver;
   localparam int N     = 64;
   localparam int CW    = $clog2(N + 1);
   localparam int IW    = $clog2(N);
   localparam int CLK_P = 10;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [N-1:0]  resp_vec = '0;
   logic          load = 0;
   logic          next = 0;
   logic [1:0]    status;
   logic [CW-1:0] count;
   logic [IW-1:0] index;
   logic          valid;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] model = '0;

   resp_resolver #(.N(N)) u0 (
      .clk(clk), .rst_n(rst_n), .resp_vec(resp_vec), .load(load),
      .next(next), .status(status), .count(count), .index(index),
      .valid(valid)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic int f_count(input logic [N-1:0] v);
      int s = 0;
      for (int i = 0; i < N; i++) s += int'(v[i]);
      return s;
   endfunction

   function automatic int f_index(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return 0;
   endfunction

   function automatic int f_status(input logic [N-1:0] v);
      int c = f_count(v);
      return (c == 0) ? 0 : ((c == 1) ? 1 : 2);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk({tag, " R1 status"}, int'(status), f_status(model));
      chk({tag, " R2 count"},  int'(count),  f_count(model));
      chk({tag, " R3 valid"},  int'(valid),  int'(model != '0));
      chk({tag, " R3 index"},  int'(index),  f_index(model));
   endtask

   // one command, one edge, sample before the next edge
   task automatic step(input logic ld, input logic nx, input logic [N-1:0] v);
      @(negedge clk);
      load = ld; next = nx; resp_vec = v;
      @(posedge clk);
      #1;
      load = 0; next = 0;
      if (ld) model = v;
      else if (nx && model != '0) model[f_index(model)] = 1'b0;
   endtask

   function automatic logic [N-1:0] rnd_vec(input int density);
      logic [N-1:0] v = '0;
      for (int i = 0; i < N; i++) v[i] = (($urandom % 100) < density);
      return v;
   endfunction

   initial begin
      logic [N-1:0] v;
      int prev;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset status", int'(status), 0);
      chk("R8 reset count",  int'(count),  0);
      chk("R8 reset valid",  int'(valid),  0);
      @(negedge clk); rst_n = 1;

      // empty set
      step(1, 0, '0);
      chk_all("R6 empty");
      chk("R6 index zero", int'(index), 0);
      step(0, 1, '0);
      chk_all("R5 next on empty");

      // last position only
      v = '0; v[N-1] = 1'b1;
      step(1, 0, v);
      chk_all("R9 last cell");
      chk("R9 last index", int'(index), N - 1);

      // empty rows skipped, two responders in rows 5 and 7
      v = '0; v[47] = 1'b1; v[58] = 1'b1;
      step(1, 0, v);
      chk_all("R9 skip rows");
      chk("R9 first index", int'(index), 47);
      step(0, 1, '0);
      chk_all("R7 after next");
      chk("R9 second index", int'(index), 58);
      step(0, 1, '0);
      chk_all("R6 drained");

      // load and next together: load wins
      v = 64'h0000_0000_0000_0f00;
      step(1, 0, v);
      step(1, 1, 64'h8000_0000_0000_0003);
      chk_all("R4 load beats next");
      chk("R4 count", int'(count), 3);

      // full array drain
      step(1, 0, '1);
      chk_all("R1 full");
      for (int k = 0; k < N; k++) begin
         prev = int'(count);
         step(0, 1, '0);
         chk_all("R7 full drain");
         chk("R7 decrement", int'(count), prev - 1);
      end
      step(0, 1, '0);
      chk_all("R5 extra next");

      // random loads and drains
      for (int t = 0; t < 150; t++) begin
         v = rnd_vec(int'($urandom % 30));
         step(1, 0, v);
         chk_all("R4 random load");
         for (int k = 0; k < 70 && model != '0; k++) begin
            step(0, ($urandom % 4) != 0, '0);
            chk_all("R5 random drain");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule